// File: doc/BRIEF.md
# Interrupt Controller Command and Init Sequencer

This block is the byte-wide programming port of one eight-line interrupt controller channel. A single address bit selects between a control address and a data address. Bytes written to the control address are sorted by their bit patterns into three formats: an initialisation start, a mode word (read selection, poll, special mask) and a command word (end-of-interrupt, rotation and priority commands). Bytes written to the data address are read according to a small initialisation sequencer. That sequencer loads the vector base, skips the cascade word and optionally takes a fourth word with nesting and auto-EOI options. Outside initialisation, a data write loads the mask register.

The block keeps only configuration state. The request latch and the priority resolver sit beside it and hold the request, in-service and rotation state. They receive one-cycle strobes from this block, each carrying the command code and the line number. The block gets back from them the request and in-service vectors and the current poll winner. Reads return the mask, the request vector, the in-service vector or a poll result. Each read result is registered and appears the cycle after the read strobe.

Top module: `icc_cmd_seq`

## Requirements
- R1: After reset the mask, vector base, nested mode, auto-EOI, rotate-on-auto-EOI and special mask outputs are 0, read selection points at the request vector, no strobe is active and `rdata_o` is 0.
- R2: A control write with bit 4 set pulses `init_stb_o` for one cycle and clears the mask, the special mask and the read selection. It records bit 0 as "fourth word expected". If bit 0 is 0, nested mode and auto-EOI are also cleared; if bit 0 is 1, they keep their values.
- R3: After an init start, the first data write loads `vec_base_o` from data bits 7:3. The second data write is the cascade word: it changes no output. The sequencer then expects the fourth word if one was announced, and otherwise returns to normal operation.
- R4: The fourth word sets nested mode from bit 4 and auto-EOI from bit 1, and returns the sequencer to normal operation.
- R5: In normal operation a data write loads `mask_o` with the byte. A read at address 1 returns the mask.
- R6: A control write with bit 4 = 0 and bit 3 = 1 is a mode word. When bit 1 is set, bit 0 selects what a read at address 0 returns: 1 gives the in-service vector and 0 gives the request vector. When bit 6 is set, bit 5 loads the special mask. When the gating bit is clear, the field is left unchanged.
- R7: A control write with bits 4 and 3 both 0 is a command word with code = bits 7:5. Code 0 clears rotate-on-auto-EOI and code 4 sets it. Codes 1, 3, 5, 6 and 7 pulse `cmd_stb_o` for one cycle the cycle after the write, with `cmd_kind_o` = code and `cmd_line_o` = bits 2:0. Code 2 has no effect at all.
- R8: A mode word with bit 2 set arms a poll. The next read, at either address, returns the winning line number zero-extended when `poll_valid_i` is 1, and pulses `poll_clr_stb_o` with that line. When `poll_valid_i` is 0, the read returns 7 and no strobe is pulsed. The poll is then disarmed.
- R9: `rdata_o` changes only the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 1 | 0 = control address, 1 = data address |
| wdata_i | input | 8 | Write byte |
| irr_i | input | 8 | Request vector from the latch |
| isr_i | input | 8 | In-service vector from the resolver |
| poll_valid_i | input | 1 | A poll winner exists |
| poll_line_i | input | 3 | Poll winner line |
| rdata_o | output | 8 | Registered read data |
| mask_o | output | 8 | Mask register |
| vec_base_o | output | 5 | Vector base (upper five bits of the vector) |
| nested_o | output | 1 | Special fully nested mode |
| auto_eoi_o | output | 1 | Auto end-of-interrupt mode |
| rot_aeoi_o | output | 1 | Rotate on auto end-of-interrupt |
| smask_o | output | 1 | Special mask mode |
| init_stb_o | output | 1 | One-cycle pulse: initialisation started |
| cmd_stb_o | output | 1 | One-cycle pulse: command for the resolver |
| cmd_kind_o | output | 3 | Command code of the pulse |
| cmd_line_o | output | 3 | Line number of the pulse |
| poll_clr_stb_o | output | 1 | One-cycle pulse: clear request and in-service of a polled line |
| poll_clr_line_o | output | 3 | Line to clear |

## Verification
The decoder is driven with directed byte sequences. These include full init sequences with and without the fourth word, mode words with their gating bits set and clear, every command code, and polls with and without a winner. Together they separate the three control formats, and they show that the cascade word and code 2 leave all outputs untouched. A long run of seeded random writes and reads then follows, with occasional init starts interleaved, and is compared against a bench model. This run exposes errors in step ordering: a data byte taken as mask in the middle of the sequence, or a mask write that lands on the vector base. It also exposes poll arming that leaks into a later read.

// File: rtl/icc_pkg.sv
package icc_pkg;
   typedef enum logic [1:0] {
      STEP_RUN  = 2'd0,
      STEP_BASE = 2'd1,
      STEP_CASC = 2'd2,
      STEP_TAIL = 2'd3
   } icc_step_e;

   localparam logic [2:0] CMD_ROT_CLR  = 3'd0;
   localparam logic [2:0] CMD_NOP      = 3'd2;
   localparam logic [2:0] CMD_ROT_SET  = 3'd4;

   function automatic logic cmd_has_strobe(input logic [2:0] code);
      return !(code == CMD_ROT_CLR || code == CMD_NOP || code == CMD_ROT_SET);
   endfunction
endpackage

// File: rtl/icc_init_seq.sv
module icc_init_seq
   import icc_pkg::*;
#(
   parameter int DW    = 8,
   parameter int LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 data_wr,
   input  logic [DW-1:0]        wdata,
   output logic [LINES-1:0]     mask,
   output logic [DW-$clog2(LINES)-1:0] base,
   output logic                 nested,
   output logic                 aeoi
);
   localparam int LW = $clog2(LINES);

   icc_step_e step;
   logic      want_tail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step      <= STEP_RUN;
         want_tail <= 1'b0;
         mask      <= '0;
         base      <= '0;
         nested    <= 1'b0;
         aeoi      <= 1'b0;
      end else if (start) begin
         want_tail <= wdata[0];
         mask      <= '0;
         step      <= STEP_BASE;
         if (!wdata[0]) begin
            nested <= 1'b0;
            aeoi   <= 1'b0;
         end
      end else if (data_wr) begin
         unique case (step)
            STEP_RUN:  mask <= wdata[LINES-1:0];
            STEP_BASE: begin
               base <= wdata[DW-1:LW];
               step <= STEP_CASC;
            end
            STEP_CASC: step <= want_tail ? STEP_TAIL : STEP_RUN;
            STEP_TAIL: begin
               nested <= wdata[4];
               aeoi   <= wdata[1];
               step   <= STEP_RUN;
            end
            default:   step <= STEP_RUN;
         endcase
      end
   end
endmodule

// File: rtl/icc_ocw_dec.sv
module icc_ocw_dec
   import icc_pkg::*;
#(
   parameter int DW    = 8,
   parameter int LINES = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ctl_wr,
   input  logic [DW-1:0]              wdata,
   input  logic                       poll_take,
   output logic                       rsel,
   output logic                       smask,
   output logic                       rot_aeoi,
   output logic                       poll_armed,
   output logic                       init_stb,
   output logic                       cmd_stb,
   output logic [2:0]                 cmd_kind,
   output logic [$clog2(LINES)-1:0]   cmd_line
);
   localparam int LW = $clog2(LINES);

   logic       is_init, is_mode, is_cmd;
   logic [2:0] code;

   always_comb begin
      is_init = ctl_wr && wdata[4];
      is_mode = ctl_wr && !wdata[4] && wdata[3];
      is_cmd  = ctl_wr && !wdata[4] && !wdata[3];
      code    = wdata[7:5];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsel       <= 1'b0;
         smask      <= 1'b0;
         rot_aeoi   <= 1'b0;
         poll_armed <= 1'b0;
         init_stb   <= 1'b0;
         cmd_stb    <= 1'b0;
         cmd_kind   <= '0;
         cmd_line   <= '0;
      end else begin
         init_stb <= is_init;
         cmd_stb  <= is_cmd && cmd_has_strobe(code);
         if (is_cmd) begin
            cmd_kind <= code;
            cmd_line <= wdata[LW-1:0];
            if (code == CMD_ROT_CLR) rot_aeoi <= 1'b0;
            if (code == CMD_ROT_SET) rot_aeoi <= 1'b1;
         end
         if (is_init) begin
            rsel  <= 1'b0;
            smask <= 1'b0;
         end
         if (is_mode) begin
            if (wdata[1]) rsel  <= wdata[0];
            if (wdata[6]) smask <= wdata[5];
         end
         if (is_mode && wdata[2]) poll_armed <= 1'b1;
         else if (poll_take)      poll_armed <= 1'b0;
      end
   end
endmodule

// File: rtl/icc_rd_path.sv
module icc_rd_path #(
   parameter int DW     = 8,
   parameter int LINES  = 8,
   parameter bit RD_REG = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_en,
   input  logic                     addr,
   input  logic [LINES-1:0]         mask,
   input  logic [LINES-1:0]         irr,
   input  logic [LINES-1:0]         isr,
   input  logic                     rsel,
   input  logic                     poll_armed,
   input  logic                     poll_valid,
   input  logic [$clog2(LINES)-1:0] poll_line,
   output logic [DW-1:0]            rdata,
   output logic                     poll_take,
   output logic                     poll_clr_stb,
   output logic [$clog2(LINES)-1:0] poll_clr_line
);
   localparam int LW = $clog2(LINES);

   logic [DW-1:0] rd_val;

   always_comb begin
      rd_val = '0;
      if (poll_armed) begin
         if (poll_valid) rd_val[LW-1:0] = poll_line;
         else            rd_val = DW'(LINES - 1);
      end else if (addr) begin
         rd_val[LINES-1:0] = mask;
      end else begin
         rd_val[LINES-1:0] = rsel ? isr : irr;
      end
      poll_take = rd_en && poll_armed;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poll_clr_stb  <= 1'b0;
         poll_clr_line <= '0;
      end else begin
         poll_clr_stb <= poll_take && poll_valid;
         if (poll_take) poll_clr_line <= poll_line;
      end
   end

   generate
      if (RD_REG) begin : g_reg_rd
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rdata <= '0;
            else if (rd_en) rdata <= rd_val;
         end
      end else begin : g_comb_rd
         assign rdata = rd_val;
      end
   endgenerate
endmodule

// File: rtl/icc_cmd_seq.sv
module icc_cmd_seq #(
   parameter int DW     = 8,
   parameter int LINES  = 8,
   parameter bit RD_REG = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en_i,
   input  logic                     rd_en_i,
   input  logic                     addr_i,
   input  logic [DW-1:0]            wdata_i,
   input  logic [LINES-1:0]         irr_i,
   input  logic [LINES-1:0]         isr_i,
   input  logic                     poll_valid_i,
   input  logic [$clog2(LINES)-1:0] poll_line_i,
   output logic [DW-1:0]            rdata_o,
   output logic [LINES-1:0]         mask_o,
   output logic [DW-$clog2(LINES)-1:0] vec_base_o,
   output logic                     nested_o,
   output logic                     auto_eoi_o,
   output logic                     rot_aeoi_o,
   output logic                     smask_o,
   output logic                     init_stb_o,
   output logic                     cmd_stb_o,
   output logic [2:0]               cmd_kind_o,
   output logic [$clog2(LINES)-1:0] cmd_line_o,
   output logic                     poll_clr_stb_o,
   output logic [$clog2(LINES)-1:0] poll_clr_line_o
);
   localparam int LW = $clog2(LINES);

   generate
      if (DW < 8) begin : g_bad_dw
         $error("icc_cmd_seq: command fields need DW >= 8");
      end
      if (LINES != (1 << LW) || LINES > DW || LINES < 8) begin : g_bad_lines
         $error("icc_cmd_seq: LINES must be a power of two between 8 and DW");
      end
   endgenerate

   logic ctl_wr, data_wr, init_go;
   logic rsel, poll_armed, poll_take;

   always_comb begin
      ctl_wr  = wr_en_i && !addr_i;
      data_wr = wr_en_i && addr_i;
      init_go = ctl_wr && wdata_i[4];
   end

   icc_init_seq #(.DW(DW), .LINES(LINES)) u_init (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (init_go),
      .data_wr (data_wr),
      .wdata   (wdata_i),
      .mask    (mask_o),
      .base    (vec_base_o),
      .nested  (nested_o),
      .aeoi    (auto_eoi_o)
   );

   icc_ocw_dec #(.DW(DW), .LINES(LINES)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (ctl_wr),
      .wdata      (wdata_i),
      .poll_take  (poll_take),
      .rsel       (rsel),
      .smask      (smask_o),
      .rot_aeoi   (rot_aeoi_o),
      .poll_armed (poll_armed),
      .init_stb   (init_stb_o),
      .cmd_stb    (cmd_stb_o),
      .cmd_kind   (cmd_kind_o),
      .cmd_line   (cmd_line_o)
   );

   icc_rd_path #(.DW(DW), .LINES(LINES), .RD_REG(RD_REG)) u_rd (
      .clk           (clk),
      .rst_n         (rst_n),
      .rd_en         (rd_en_i),
      .addr          (addr_i),
      .mask          (mask_o),
      .irr           (irr_i),
      .isr           (isr_i),
      .rsel          (rsel),
      .poll_armed    (poll_armed),
      .poll_valid    (poll_valid_i),
      .poll_line     (poll_line_i),
      .rdata         (rdata_o),
      .poll_take     (poll_take),
      .poll_clr_stb  (poll_clr_stb_o),
      .poll_clr_line (poll_clr_line_o)
   );
endmodule

// File: rtl/icc_cmd_seq_chk.sv
module icc_cmd_seq_chk #(
   parameter int DW     = 8,
   parameter int LINES  = 8,
   parameter bit RD_REG = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en_i,
   input logic                     rd_en_i,
   input logic                     addr_i,
   input logic [DW-1:0]            wdata_i,
   input logic                     poll_valid_i,
   input logic [DW-1:0]            rdata_o,
   input logic [LINES-1:0]         mask_o,
   input logic [DW-$clog2(LINES)-1:0] vec_base_o,
   input logic                     smask_o,
   input logic                     init_stb_o,
   input logic                     cmd_stb_o,
   input logic                     poll_clr_stb_o
);
   p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !addr_i && wdata_i[4]) |=> (init_stb_o && mask_o == '0 && !smask_o));

   p_base_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && addr_i) |=> $stable(vec_base_o));

   p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(mask_o));

   p_cmd_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb_o |-> $past(wr_en_i && !addr_i && wdata_i[4:3] == 2'b00));

   p_poll_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      poll_clr_stb_o |-> $past(rd_en_i && poll_valid_i));

   generate
      if (RD_REG) begin : g_rd_hold
         p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en_i |=> $stable(rdata_o));
      end
   endgenerate
endmodule

bind icc_cmd_seq icc_cmd_seq_chk #(.DW(DW), .LINES(LINES), .RD_REG(RD_REG)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en_i        (wr_en_i),
   .rd_en_i        (rd_en_i),
   .addr_i         (addr_i),
   .wdata_i        (wdata_i),
   .poll_valid_i   (poll_valid_i),
   .rdata_o        (rdata_o),
   .mask_o         (mask_o),
   .vec_base_o     (vec_base_o),
   .smask_o        (smask_o),
   .init_stb_o     (init_stb_o),
   .cmd_stb_o      (cmd_stb_o),
   .poll_clr_stb_o (poll_clr_stb_o)
);

// File: tb/icc_cmd_seq_tb.sv
module icc_cmd_seq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
   logic [7:0] wdata = '0, irr = '0, isr = '0;
   logic       pvalid = 1'b0;
   logic [2:0] pline = '0;
   logic [7:0] rdata, mask;
   logic [4:0] vbase;
   logic       nested, aeoi, rot, smask, init_stb, cmd_stb, pclr_stb;
   logic [2:0] cmd_kind, cmd_line, pclr_line;

   int n_chk = 0, n_fail = 0;

   // bench model state
   logic [7:0] m_mask, m_rdata;
   logic [4:0] m_base;
   logic [1:0] m_step;
   logic       m_tail, m_nested, m_aeoi, m_rot, m_smask, m_rsel, m_poll;
   logic       e_init, e_cmd, e_pclr;
   logic [2:0] e_kind, e_line, e_pline;

   always #10 clk = ~clk;

   icc_cmd_seq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
      .wdata_i(wdata), .irr_i(irr), .isr_i(isr), .poll_valid_i(pvalid),
      .poll_line_i(pline), .rdata_o(rdata), .mask_o(mask), .vec_base_o(vbase),
      .nested_o(nested), .auto_eoi_o(aeoi), .rot_aeoi_o(rot), .smask_o(smask),
      .init_stb_o(init_stb), .cmd_stb_o(cmd_stb), .cmd_kind_o(cmd_kind),
      .cmd_line_o(cmd_line), .poll_clr_stb_o(pclr_stb), .poll_clr_line_o(pclr_line)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %0h exp %0h", req, got, exp);
      end
   endtask

   function automatic logic strobe_code(input logic [2:0] c);
      return !(c == 3'd0 || c == 3'd2 || c == 3'd4);
   endfunction

   task automatic model_reset();
      m_mask = 0; m_rdata = 0; m_base = 0; m_step = 0; m_tail = 0;
      m_nested = 0; m_aeoi = 0; m_rot = 0; m_smask = 0; m_rsel = 0; m_poll = 0;
      e_init = 0; e_cmd = 0; e_pclr = 0; e_kind = 0; e_line = 0; e_pline = 0;
   endtask

   task automatic model_write(input logic a, input logic [7:0] d);
      e_init = 0; e_cmd = 0; e_pclr = 0;
      if (a) begin
         case (m_step)
            2'd0: m_mask = d;
            2'd1: begin m_base = d[7:3]; m_step = 2'd2; end
            2'd2: m_step = m_tail ? 2'd3 : 2'd0;
            default: begin m_nested = d[4]; m_aeoi = d[1]; m_step = 2'd0; end
         endcase
      end else if (d[4]) begin
         e_init = 1; m_tail = d[0]; m_mask = 0; m_smask = 0; m_rsel = 0; m_step = 2'd1;
         if (!d[0]) begin m_nested = 0; m_aeoi = 0; end
      end else if (d[3]) begin
         if (d[2]) m_poll = 1;
         if (d[1]) m_rsel = d[0];
         if (d[6]) m_smask = d[5];
      end else begin
         if (d[7:5] == 3'd0) m_rot = 0;
         if (d[7:5] == 3'd4) m_rot = 1;
         if (strobe_code(d[7:5])) begin e_cmd = 1; e_kind = d[7:5]; e_line = d[2:0]; end
      end
   endtask

   task automatic model_read(input logic a);
      e_init = 0; e_cmd = 0; e_pclr = 0;
      if (m_poll) begin
         m_poll = 0;
         if (pvalid) begin m_rdata = {5'd0, pline}; e_pclr = 1; e_pline = pline; end
         else m_rdata = 8'd7;
      end else if (a) m_rdata = m_mask;
      else m_rdata = m_rsel ? isr : irr;
   endtask

   task automatic check_all(input string req);
      chk({req, " mask"}, mask, m_mask);
      chk({req, " base"}, vbase, m_base);
      chk({req, " nested"}, nested, m_nested);
      chk({req, " aeoi"}, aeoi, m_aeoi);
      chk({req, " rot"}, rot, m_rot);
      chk({req, " smask"}, smask, m_smask);
      chk({req, " init_stb"}, init_stb, e_init);
      chk({req, " cmd_stb"}, cmd_stb, e_cmd);
      if (e_cmd) begin
         chk({req, " cmd_kind"}, cmd_kind, e_kind);
         chk({req, " cmd_line"}, cmd_line, e_line);
      end
      chk({req, " poll_stb"}, pclr_stb, e_pclr);
      if (e_pclr) chk({req, " poll_line"}, pclr_line, e_pline);
      chk({req, " rdata"}, rdata, m_rdata);
   endtask

   task automatic do_wr(input string req, input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1; addr = a; wdata = d;
      model_write(a, d);
      @(negedge clk);
      wr_en = 0;
      check_all(req);
   endtask

   task automatic do_rd(input string req, input logic a);
      @(negedge clk);
      rd_en = 1; addr = a;
      model_read(a);
      @(negedge clk);
      rd_en = 0;
      check_all(req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish got 0 exp 1");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      check_all("R1 reset");

      irr = 8'h3C; isr = 8'h81;
      // R2/R3/R4: init with fourth word
      do_wr("R2 start4", 0, 8'h11);
      do_wr("R3 base", 1, 8'h4F);
      chk("R3 base value", vbase, 5'd9);
      do_wr("R3 cascade ignored", 1, 8'hFF);
      do_wr("R4 tail", 1, 8'h12);
      chk("R4 nested", nested, 1'b1);
      chk("R4 aeoi", aeoi, 1'b1);
      do_wr("R5 mask", 1, 8'hA5);
      do_rd("R5 read mask", 1);
      chk("R5 mask value", rdata, 8'hA5);
      // R2: start with fourth word announced keeps modes
      do_wr("R2 keep", 0, 8'h13);
      chk("R2 nested kept", nested, 1'b1);
      do_wr("R3 base2", 1, 8'h08);
      do_wr("R3 casc2", 1, 8'h00);
      do_wr("R4 tail2", 1, 8'h00);
      // R2: no fourth word clears modes, sequence skips tail
      do_wr("R4 tail3 prep", 0, 8'h11);
      do_wr("R3 b", 1, 8'h00); do_wr("R3 c", 1, 8'h00); do_wr("R4 set", 1, 8'h12);
      do_wr("R2 clear", 0, 8'h10);
      chk("R2 aeoi cleared", aeoi, 1'b0);
      do_wr("R3 b3", 1, 8'hF8); do_wr("R3 c3", 1, 8'h02);
      do_wr("R3 back to normal", 1, 8'h5A);
      chk("R3 mask after no tail", mask, 8'h5A);
      // R6 mode words
      do_wr("R6 sel isr", 0, 8'h0B);
      do_rd("R6 read isr", 0);
      do_wr("R6 ungated", 0, 8'h08);
      do_rd("R6 still isr", 0);
      do_wr("R6 smask", 0, 8'h68);
      do_wr("R6 sel irr", 0, 8'h0A);
      do_rd("R6 read irr", 0);
      // R7 commands
      for (int c = 0; c < 8; c++) do_wr("R7 cmd", 0, {c[2:0], 5'b00101});
      do_wr("R7 rot set", 0, 8'h80);
      do_wr("R7 nop", 0, 8'h47);
      // R8 poll
      pvalid = 1; pline = 3'd5;
      do_wr("R8 arm", 0, 8'h0C);
      do_rd("R8 poll hit", 1);
      do_rd("R8 disarmed", 1);
      pvalid = 0;
      do_wr("R8 arm2", 0, 8'h0C);
      do_rd("R8 poll miss", 0);
      chk("R8 miss value", rdata, 8'h07);
      // R9 hold across writes
      do_wr("R9 hold", 1, 8'h33);

      void'($urandom(32'h0C0FFEE5));
      for (int i = 0; i < 3000; i++) begin
         logic a;
         logic [7:0] d;
         a = 1'($urandom);
         d = 8'($urandom);
         irr = 8'($urandom); isr = 8'($urandom);
         pvalid = 1'($urandom); pline = 3'($urandom);
         if (!a && ($urandom % 8) != 0) d[4] = 1'b0;
         if (($urandom % 3) == 0) do_rd("R9 rand read", a);
         else do_wr("R7 rand write", a, d);
      end

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule